// File: doc/BRIEF.md
# Banked Issue Queue Size Controller

This controller decides how many banks of a multi-bank issue queue are powered. Each bank has its own enable. Driving an enable low turns off that bank's wakeup tag broadcast and the supply to its storage cells. The controller watches one signal, asserted in every cycle in which dispatch is held back because the active part of the queue is full. It counts those cycles over fixed sampling windows. At the end of each window it adds one bank when stalls were frequent and removes one bank when they were rare.

The enabled banks always form a contiguous group starting at bank 0, so the top enabled bank is the only one that can be added or removed. A bank is removed in two steps, because a bank may only lose power once it is empty:

- First the bank is closed to new dispatch.
- Its enable drops only once the per-bank occupancy inputs show that the bank has drained.

A newly enabled bank is given one cycle to settle before dispatch may use it. The controller reports per-bank enables, per-bank dispatch permission and the usable capacity in entries. The queue storage, wakeup logic and select logic are outside this block.

Top module: `iq_bank_sizer`

## Requirements
- R1: After reset, all 8 banks are enabled and open for dispatch, and `active_cap` reads 80.
- R2: A sampling window is `INTERVAL` cycles long, and the first window starts at the first clock edge after reset is released. The stall count covers exactly the cycles of one window and restarts from zero in the next window, so stalls never carry over from one window to the next.
- R3: If a window's stall count is strictly greater than `HIGH_MARK`, one bank is added. A count equal to `HIGH_MARK` causes no growth.
- R4: If a window's stall count is strictly less than `LOW_MARK`, one bank is marked for removal. A count equal to `LOW_MARK` causes no shrink.
- R5: The stall counter saturates at its maximum value, 2^`STALL_W`-1, and does not wrap around.
- R6: While a removal is pending, the top bank keeps `bank_en` high but has `bank_ok` low. This lasts for as long as its occupancy is non-zero.
- R7: A pending bank's `bank_en` goes low one cycle after the first cycle in which its occupancy input reads zero.
- R8: When a bank is added, its `bank_en` rises in the cycle after the window boundary, and its `bank_ok` rises one cycle later.
- R9: A growth decision made while a removal is pending cancels the removal. The pending bank becomes open for dispatch in the next cycle, and no additional bank is enabled.
- R10: The enabled banks always form a contiguous group starting at bank 0. At least 1 bank and at most 8 banks are enabled; a request to go beyond either limit is ignored.
- R11: `active_cap` equals the number of banks with `bank_ok` high, multiplied by 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_full | input | 1 | High in each cycle in which dispatch stalls because the queue is full |
| bank_occ | input | NUM_BANKS*OCC_W (32) | Valid-entry count for each bank; bank i occupies bits [i*OCC_W +: OCC_W] |
| bank_en | output | NUM_BANKS (8) | Per-bank power and wakeup enable |
| bank_ok | output | NUM_BANKS (8) | Per-bank permission to accept new dispatch |
| active_cap | output | CAP_W (7) | Number of entries currently usable for dispatch |

## Verification
The bench places stall counts exactly on and on either side of both thresholds. A controller that used a non-strict comparison would therefore grow or shrink one window too early. It also splits stalls across two adjacent windows and uses counts that overflow the counter width. A counter that was not cleared at the window boundary, or one that wrapped instead of saturating, would make the wrong decision in those windows.

For removal, the bench holds the top bank occupied and checks that the enable stays high until the occupancy reads zero, then drops exactly one cycle later. It also sends a growth decision while a removal is pending; a design that added a second bank instead of cancelling would show an extra enable. Finally, it drives the bank count to both limits and checks the one-cycle dispatch hold-off on every newly enabled bank.

// File: rtl/iq_bank_sizer.sv
module iq_bank_sizer #(
  parameter int NUM_BANKS    = 8,
  parameter int BANK_ENTRIES = 10,
  parameter int INTERVAL     = 1024,
  parameter int HIGH_MARK    = 64,
  parameter int LOW_MARK     = 8,
  parameter int STALL_W      = 8,
  parameter int OCC_W        = $clog2(BANK_ENTRIES + 1),
  parameter int CAP_W        = $clog2(NUM_BANKS * BANK_ENTRIES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         stall_full,
  input  logic [NUM_BANKS*OCC_W-1:0]   bank_occ,
  output logic [NUM_BANKS-1:0]         bank_en,
  output logic [NUM_BANKS-1:0]         bank_ok,
  output logic [CAP_W-1:0]             active_cap
);

  localparam int CNT_W = $clog2(NUM_BANKS + 1);
  localparam int IV_W  = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [STALL_W-1:0] SAT = {STALL_W{1'b1}};
  localparam logic [STALL_W-1:0] HI  = STALL_W'(HIGH_MARK);
  localparam logic [STALL_W-1:0] LO  = STALL_W'(LOW_MARK);
  localparam logic [CNT_W-1:0]   MAXB = CNT_W'(NUM_BANKS);
  localparam logic [CNT_W-1:0]   ONE  = CNT_W'(1);

  logic [CNT_W-1:0]   en_cnt;
  logic               pend;
  logic               arm;
  logic [IV_W-1:0]    iv;
  logic [STALL_W-1:0] stalls;
  logic [STALL_W-1:0] stall_sum;
  logic [OCC_W-1:0]   occ_top;

  wire boundary = (iv == IV_W'(INTERVAL - 1));
  assign stall_sum = (stall_full && stalls != SAT) ? stalls + 1'b1 : stalls;

  wire grow_req   = boundary && (stall_sum > HI);
  wire shrink_req = boundary && (stall_sum < LO);

  always_comb begin
    occ_top = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (CNT_W'(i + 1) == en_cnt) occ_top = bank_occ[i*OCC_W +: OCC_W];
  end

  wire top_empty = (occ_top == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_cnt <= MAXB;
      pend   <= 1'b0;
      arm    <= 1'b0;
      iv     <= '0;
      stalls <= '0;
    end else begin
      iv     <= boundary ? '0 : iv + 1'b1;
      stalls <= boundary ? '0 : stall_sum;
      arm    <= 1'b0;
      if (grow_req) begin
        if (pend) begin
          pend <= 1'b0;
        end else if (en_cnt != MAXB) begin
          en_cnt <= en_cnt + 1'b1;
          arm    <= 1'b1;
        end
      end else if (pend && top_empty) begin
        en_cnt <= en_cnt - 1'b1;
        pend   <= 1'b0;
      end else if (shrink_req && en_cnt != ONE) begin
        pend <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_en[g] = CNT_W'(g) < en_cnt;
    assign bank_ok[g] = bank_en[g] && !((pend || arm) && CNT_W'(g + 1) == en_cnt);
  end

  assign active_cap = CAP_W'((int'(en_cnt) - int'(pend) - int'(arm)) * BANK_ENTRIES);

endmodule

// File: rtl/iq_bank_sizer_chk.sv
module iq_bank_sizer_chk #(
  parameter int NB    = 8,
  parameter int E     = 10,
  parameter int OCC_W = 4,
  parameter int CAP_W = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NB*OCC_W-1:0]   bank_occ,
  input logic [NB-1:0]         bank_en,
  input logic [NB-1:0]         bank_ok,
  input logic [CAP_W-1:0]      active_cap
);

  assert_contiguous_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bank_en[0] && ((bank_en & (bank_en + 1'b1)) == '0));

  assert_ok_within_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_ok & ~bank_en) == '0);

  assert_cap_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_cap) == $countones(bank_ok) * E);

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(bank_en) <= $countones($past(bank_en)) + 1) &&
    ($countones(bank_en) + 1 >= $countones($past(bank_en))));

  for (genvar i = 0; i < NB; i++) begin : g_chk
    assert_drop_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_en[i]) |-> ($past(bank_occ[i*OCC_W +: OCC_W]) == '0));
    assert_settle_before_use_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_en[i]) |-> !bank_ok[i]);
  end

endmodule

bind iq_bank_sizer iq_bank_sizer_chk #(
  .NB(NUM_BANKS), .E(BANK_ENTRIES), .OCC_W(OCC_W), .CAP_W(CAP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_occ(bank_occ),
  .bank_en(bank_en), .bank_ok(bank_ok), .active_cap(active_cap)
);

// File: tb/tb_iq_bank_sizer.sv
`timescale 1ns/1ps
module tb_iq_bank_sizer;
  localparam int NB = 8, E = 10, IV = 16, HI = 4, LO = 2, SW = 3, OW = 4, CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall_full = 1'b0;
  logic [OW-1:0] occ [NB];
  logic [NB*OW-1:0] bank_occ;
  logic [NB-1:0] bank_en, bank_ok;
  logic [CW-1:0] active_cap;

  int errors = 0, checks = 0, cyc = 0;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < NB; i++) bank_occ[i*OW +: OW] = occ[i];

  iq_bank_sizer #(.NUM_BANKS(NB), .BANK_ENTRIES(E), .INTERVAL(IV),
                  .HIGH_MARK(HI), .LOW_MARK(LO), .STALL_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .stall_full(stall_full), .bank_occ(bank_occ),
    .bank_en(bank_en), .bank_ok(bank_ok), .active_cap(active_cap));

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic state(string req, int en, int ok, int cap);
    chk(req, "bank_en", int'(bank_en), en);
    chk(req, "bank_ok", int'(bank_ok), ok);
    chk(req, "active_cap", int'(active_cap), cap);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
    end
    stall_full = 1'b0;
  endtask

  // runs to the end of the current window, stalling in its first nst cycles
  task automatic run_window(int nst);
    int rem = IV - (cyc % IV);
    for (int i = 0; i < rem; i++) begin
      stall_full = (i < nst);
      @(negedge clk);
      cyc++;
    end
    stall_full = 1'b0;
  endtask

  task automatic t_reset;
    state("R1", 'hFF, 'hFF, 80);
  endtask

  task automatic t_deferred_shrink;
    occ[7] = 4'd3;
    run_window(0);
    state("R6", 'hFF, 'h7F, 70);
    step(3);
    state("R6", 'hFF, 'h7F, 70);
    occ[7] = 4'd0;
    step(1);
    state("R7", 'h7F, 'h7F, 70);
  endtask

  task automatic t_empty_shrink;
    run_window(1);
    state("R4", 'h7F, 'h3F, 60);
    step(1);
    state("R7", 'h3F, 'h3F, 60);
  endtask

  task automatic t_thresholds;
    run_window(LO);
    state("R4", 'h3F, 'h3F, 60);
    run_window(HI);
    state("R3", 'h3F, 'h3F, 60);
  endtask

  task automatic t_grow;
    run_window(HI + 1);
    state("R8", 'h7F, 'h3F, 60);
    step(1);
    state("R8", 'h7F, 'h7F, 70);
  endtask

  task automatic t_cancel;
    occ[6] = 4'd5;
    run_window(0);
    state("R6", 'h7F, 'h3F, 60);
    run_window(IV);
    state("R9", 'h7F, 'h7F, 70);
    step(1);
    state("R9", 'h7F, 'h7F, 70);
    occ[6] = 4'd0;
  endtask

  task automatic t_saturate;
    run_window(12);
    state("R5", 'hFF, 'h7F, 70);
    step(1);
    state("R5", 'hFF, 'hFF, 80);
  endtask

  task automatic t_limits;
    run_window(IV);
    state("R10", 'hFF, 'hFF, 80);
    for (int k = 0; k < NB - 1; k++) run_window(0);
    step(1);
    state("R10", 'h01, 'h01, 10);
    run_window(0);
    step(1);
    state("R10", 'h01, 'h01, 10);
  endtask

  task automatic t_window_clear;
    run_window(3);
    run_window(3);
    state("R2", 'h01, 'h01, 10);
    run_window(HI + 1);
    step(1);
    state("R2", 'h03, 'h03, 20);
  endtask

  initial begin
    for (int i = 0; i < NB; i++) occ[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_deferred_shrink();
    t_empty_shrink();
    t_thresholds();
    t_grow();
    t_cancel();
    t_saturate();
    t_limits();
    t_window_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule